// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A synchronous up-counter of `WIDTH` bits (4 by default, so modulo 16) with a synchronous parallel preset and two count enables. The "parallel" enable is meant to be shared by every stage of a chain. The "trickle" enable is meant to be fed from the previous stage's terminal-count output. The count advances only when both enables are high. The terminal-count output is gated by the trickle enable alone. Chaining stages this way gives a wide counter that is fully synchronous: every stage samples its enables on the same clock edge, and the carry ripples only through combinational terminal-count gates.

The parameter `ASYNC_CLR` selects the clear style at build time. With `ASYNC_CLR = 1`, the active-low clear empties the counter as soon as it goes low, without waiting for a clock. With `ASYNC_CLR = 0`, the clear takes effect on the next rising clock edge. The block carries no data stream: every pin is a plain control or status signal. There is therefore no valid/ready handshake and no back-pressure.

Top module: `preset_counter`

## Requirements
- R1: With `ASYNC_CLR = 1`, a low `clr_n` forces `count` to zero at once, without a clock edge, and holds it there while low.
- R2: With `ASYNC_CLR = 0`, a low `clr_n` sampled at a rising edge makes `count` zero after that edge, even when `load_n` is low or both enables are high.
- R3: With clear inactive, `load_n` low at a rising edge copies `preset` into `count`, whatever `en_par` and `en_trk` are.
- R4: With clear inactive and `load_n` high, `count` increments by one at a rising edge when `en_par` and `en_trk` are both high.
- R5: With clear inactive and `load_n` high, `count` keeps its value when either `en_par` or `en_trk` is low.
- R6: Incrementing from the all-ones value (15 for `WIDTH = 4`) yields zero.
- R7: `term` is 1 exactly when `count` is all ones and `en_trk` is 1. It follows `en_trk` combinationally and does not depend on `en_par` or `load_n`.
- R8: When three stages are chained, with each stage's `term` driving the next stage's `en_trk` and all stages sharing `en_par`, the stages form a 12-bit synchronous counter that wraps from 4095 to 0. Stage 0 holds the low nibble.
- R9: Apart from the asynchronous clear, `count` changes only at a rising edge of `clk`. Input changes between edges leave it untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous per `ASYNC_CLR` |
| load_n | input | 1 | Active-low synchronous preset load |
| en_par | input | 1 | Parallel count enable, shared across a chain |
| en_trk | input | 1 | Trickle count enable; also gates `term` |
| preset | input | WIDTH | Value copied in on a load |
| count | output | WIDTH | Current count |
| term | output | 1 | Terminal count: all ones while `en_trk` is high |

## Verification
Two pairs of functions can collide in one cycle: a load with a count request, and a clear with a load. The bench raises both enables during load cycles, and for the synchronous variant it drops `clr_n` together with `load_n`. A scoreboard model then judges the outcome by strict priority: clear first, then load, then count. A third overlap lines up the terminal count with a hold or a load. The bench holds the all-ones value with `en_par` low and toggles `en_trk` between edges, so that `term` can be seen to follow the trickle enable alone. A three-stage chain is counted through 4095 to 0 to confirm that the carry crosses stages on the same edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    MODE_CLEAR = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_STEP  = 2'd2,
    MODE_KEEP  = 2'd3
  } cnt_mode_t;
endpackage

// File: rtl/cnt_mode_sel.sv
module cnt_mode_sel
  import cnt_pkg::*;
(
  input  logic      sync_clr,
  input  logic      load_n,
  input  logic      en_par,
  input  logic      en_trk,
  output cnt_mode_t mode
);
  // strict priority: clear, load, step, keep
  always_comb begin
    if (sync_clr)              mode = MODE_CLEAR;
    else if (!load_n)          mode = MODE_LOAD;
    else if (en_par && en_trk) mode = MODE_STEP;
    else                       mode = MODE_KEEP;
  end
endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_mode_t        mode,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (mode)
      MODE_CLEAR: nxt = '0;
      MODE_LOAD:  nxt = preset;
      MODE_STEP:  nxt = cur + ONE;   // natural wrap at all ones
      default:    nxt = cur;
    endcase
  end
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= nxt;
  end
endmodule

// File: rtl/cnt_term.sv
module cnt_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_trk,
  output logic             term
);
  assign term = en_trk & (&q);
endmodule

// File: rtl/preset_counter.sv
module preset_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_par,
  input  logic             en_trk,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             term
);
  logic             sync_clr;
  logic             arst_n;
  cnt_mode_t        mode;
  logic [WIDTH-1:0] nxt;

  // clear style chosen at build time
  generate
    if (ASYNC_CLR) begin : g_async
      assign arst_n   = clr_n;
      assign sync_clr = 1'b0;
    end else begin : g_sync
      assign arst_n   = 1'b1;
      assign sync_clr = ~clr_n;
    end
  endgenerate

  cnt_mode_sel u_mode (
    .sync_clr (sync_clr),
    .load_n   (load_n),
    .en_par   (en_par),
    .en_trk   (en_trk),
    .mode     (mode)
  );

  cnt_next #(.WIDTH(WIDTH)) u_next (
    .mode   (mode),
    .cur    (count),
    .preset (preset),
    .nxt    (nxt)
  );

  cnt_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk    (clk),
    .arst_n (arst_n),
    .nxt    (nxt),
    .q      (count)
  );

  cnt_term #(.WIDTH(WIDTH)) u_term (
    .q      (count),
    .en_trk (en_trk),
    .term   (term)
  );
endmodule

// File: rtl/preset_counter_chk.sv
module preset_counter_chk #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic             en_par,
  input logic             en_trk,
  input logic [WIDTH-1:0] preset,
  input logic [WIDTH-1:0] count,
  input logic             term
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  a_r3_load_wins: assert property (@(posedge clk) disable iff (!clr_n)
    (!load_n) |=> (count == $past(preset)));

  a_r4_step: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_trk) |=> (count == $past(count) + ONE));

  a_r5_hold: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_par && en_trk)) |=> $stable(count));

  a_r7_term_gated: assert property (@(posedge clk) disable iff (!clr_n)
    (!en_trk) |-> !term);

  a_r7_term_full: assert property (@(posedge clk) disable iff (!clr_n)
    term |-> (&count));

  generate
    if (ASYNC_CLR) begin : g_async_chk
      // R1: the clear acts before any edge, so count is zero at every edge while low
      always @(posedge clk) begin
        if (clr_n === 1'b0)
          a_r1_async_zero: assert (count == '0);
      end
    end else begin : g_sync_chk
      logic clr_seen = 1'b0;
      always @(posedge clk) begin
        if (clr_seen)
          a_r2_sync_zero: assert (count == '0);
        clr_seen <= (clr_n === 1'b0);
      end
    end
  endgenerate
endmodule

bind preset_counter preset_counter_chk #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_chk (
  .clk    (clk),
  .clr_n  (clr_n),
  .load_n (load_n),
  .en_par (en_par),
  .en_trk (en_trk),
  .preset (preset),
  .count  (count),
  .term   (term)
);

// File: tb/preset_counter_tb.sv
module preset_counter_tb;
  logic        clk = 1'b0;
  logic        clr_n = 1'b0, sclr_n = 1'b0, load_n = 1'b1;
  logic        par = 1'b0, trk = 1'b0;
  logic [11:0] pre = '0;
  logic [3:0]  c0, c1, c2, cs;
  logic        t0, t1, t2, ts;
  wire  [11:0] cnt12 = {c2, c1, c0};

  always #10 clk = ~clk;   // 50 MHz

  // stage 0 of the chain (asynchronous clear)
  preset_counter #(.WIDTH(4), .ASYNC_CLR(1'b1)) u_dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(par), .en_trk(trk),
    .preset(pre[3:0]), .count(c0), .term(t0));
  preset_counter #(.WIDTH(4), .ASYNC_CLR(1'b1)) u_s1 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(par), .en_trk(t0),
    .preset(pre[7:4]), .count(c1), .term(t1));
  preset_counter #(.WIDTH(4), .ASYNC_CLR(1'b1)) u_s2 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(par), .en_trk(t1),
    .preset(pre[11:8]), .count(c2), .term(t2));
  // standalone synchronous-clear variant
  preset_counter #(.WIDTH(4), .ASYNC_CLR(1'b0)) u_sync (
    .clk(clk), .clr_n(sclr_n), .load_n(load_n), .en_par(par), .en_trk(trk),
    .preset(pre[3:0]), .count(cs), .term(ts));

  typedef struct packed {
    logic [11:0] c12;
    logic        t12;
    logic [3:0]  cs;
    logic        ts;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    vectors = 0, miscompares = 0;
  logic [11:0] m12 = '0;
  logic [3:0]  ms  = '0;

  task automatic apply(input logic c, input logic sc, input logic l,
                       input logic p, input logic t, input logic [11:0] v,
                       input string tag);
    exp_t e;
    @(negedge clk);
    clr_n = c; sclr_n = sc; load_n = l; par = p; trk = t; pre = v;
    if (!c)          m12 = '0;
    else if (!l)     m12 = v;
    else if (p && t) m12 = m12 + 12'd1;
    if (!sc)         ms = '0;
    else if (!l)     ms = v[3:0];
    else if (p && t) ms = ms + 4'd1;
    e.c12 = m12;
    e.t12 = t && (m12 == 12'hFFF);
    e.cs  = ms;
    e.ts  = t && (ms == 4'hF);
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  task automatic direct(input logic [15:0] act, input logic [15:0] exp,
                        input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expq.size() > 0) begin
        exp_t  e;
        string tg;
        e  = expq.pop_front();
        tg = tagq.pop_front();
        vectors++;
        if ({cnt12, t2, cs, ts} !== {e.c12, e.t12, e.cs, e.ts}) begin
          miscompares++;
          $display("FAIL %s actual cnt12=%h term=%b sync=%h sterm=%b expected cnt12=%h term=%b sync=%h sterm=%b",
                   tg, cnt12, t2, cs, ts, e.c12, e.t12, e.cs, e.ts);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #3;
    direct({4'h0, cnt12}, 16'h0000, "R1 reset state before any edge");
    apply(0, 0, 1, 1, 1, 12'h000, "R1 R2 clear");
    apply(0, 0, 0, 1, 1, 12'h5A5, "R1 R2 clear beats load");
    // R3: load beats count
    apply(1, 1, 0, 1, 1, 12'hABC, "R3 load with enables high");
    for (int i = 0; i < 5; i++) apply(1, 1, 1, 1, 1, 12'h000, "R4 count");
    apply(1, 1, 1, 0, 1, 12'h000, "R5 hold par low");
    apply(1, 1, 1, 1, 0, 12'h000, "R5 hold trk low");
    apply(1, 1, 0, 0, 0, 12'h3C7, "R3 load with enables low");
    // wrap of a single stage and of the chain
    apply(1, 1, 0, 0, 0, 12'hFFD, "R3 load near top");
    for (int i = 0; i < 3; i++) apply(1, 1, 1, 1, 1, 12'h000, "R6 R7 count through wrap");
    // synchronous clear coinciding with load
    apply(1, 0, 0, 1, 1, 12'h46E, "R2 sync clear beats load");
    // R7: hold at all ones, term follows trk only
    apply(1, 1, 0, 1, 1, 12'hFFF, "R3 load all ones");
    apply(1, 1, 1, 0, 0, 12'h000, "R7 hold term low");
    apply(1, 1, 1, 0, 1, 12'h000, "R7 term with par low");
    @(posedge clk); #7;
    trk = 1'b0; #1;
    direct({14'h0, t2, ts}, 16'h0000, "R7 term drops with trk between edges");
    trk = 1'b1; #1;
    direct({14'h0, t2, ts}, 16'h0003, "R7 term rises with trk between edges");
    load_n = 1'b0; pre = 12'h123; #1;
    direct({14'h0, t2, ts}, 16'h0003, "R7 term ignores load");
    direct({cnt12, cs}, {12'hFFF, 4'hF}, "R9 no change between edges");
    // R1: asynchronous clear between edges
    apply(1, 1, 0, 0, 0, 12'h9B2, "R3 load before async clear");
    @(posedge clk); #7;
    clr_n = 1'b0; m12 = '0; #1;
    direct({4'h0, cnt12}, 16'h0000, "R1 async clear without edge");
    direct({12'h0, cs}, 16'h0002, "R9 sync variant untouched by async event");
    apply(0, 1, 1, 1, 1, 12'h000, "R1 clear held low");
    // R8: 12-bit chain wraps 4095 to 0
    apply(1, 1, 0, 1, 1, 12'hFF0, "R3 load chain");
    for (int i = 0; i < 20; i++) apply(1, 1, 1, 1, 1, 12'h000, "R8 chain wrap");
    apply(1, 1, 0, 1, 1, 12'h0F8, "R3 load mid");
    for (int i = 0; i < 4100; i++) apply(1, 1, 1, 1, 1, 12'h000, "R8 full chain cycle");
    apply(1, 1, 1, 1, 0, 12'h000, "R5 chain hold");
    @(posedge clk); #8;
    @(posedge clk); #8;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule